// File: doc/BRIEF.md
# Load-Multiple Instruction Sequencer

This block takes one 16-bit load-multiple instruction of the increment-after kind and carries it out. On a start strobe it checks the opcode field and reads the base register through a register-file read port. It then walks an 8-bit register list from the lowest set bit to the highest. For each set bit it issues one word read to memory and writes the returned word into the selected register.

Addresses start at the base value and climb by one word per load. When the base register is not among the loaded registers, the sequencer finishes by writing the advanced address back into the base. A done pulse closes every legal instruction. A malformed instruction is refused with a one-cycle illegal flag, and it causes no memory traffic at all.

The sequencer sits between an instruction issue stage, a register file with a combinational read port, and a memory read port that may take any number of cycles to answer.

Top module: `ldm_seq`

## Requirements
- R1: An instruction is legal when bits [15:11] equal 5'b11001 and bits [7:0] are non-zero. Bits [10:8] give the base register number. In the cycle `start` is high in idle, `rf_raddr` equals bits [10:8], and a legal instruction raises `mem_req` in the next cycle.
- R2: An opcode other than 5'b11001, or an all-zero list, raises `illegal` for exactly the one cycle after `start`. It produces no `mem_req`, no `rf_we` and no `done`.
- R3: A legal instruction makes exactly one accepted memory read per set list bit. The first address is the base value and each later one is 4 higher. While `mem_rvalid` is low, `mem_req` stays high and `mem_addr` is held.
- R4: List bit n selects register n. Registers are written in ascending number order. Each load writes `mem_rdata` to `rf_waddr` = n with `rf_we` high, in the cycle its `mem_rvalid` is seen.
- R5: When the base register is not in the list, the cycle after the last load writes base + 4 × (number of set list bits) to the base register.
- R6: When the base register is in the list, no write-back happens, and the base keeps the value loaded from memory.
- R7: `done` is high for one cycle, in the cycle right after the final register write of a legal instruction.
- R8: `start` is ignored while an instruction is in progress.
- R9: After reset, `mem_req`, `rf_we`, `done` and `illegal` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Instruction strobe, sampled in idle |
| instr | input | 16 | Instruction word |
| rf_raddr | output | 3 | Register-file read index (base register) |
| rf_rdata | input | DATA_W | Register-file read data |
| rf_we | output | 1 | Register-file write enable |
| rf_waddr | output | 3 | Register-file write index |
| rf_wdata | output | DATA_W | Register-file write data |
| mem_req | output | 1 | Memory read request, held until valid |
| mem_addr | output | DATA_W | Byte address of the word read |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | DATA_W | Read data |
| done | output | 1 | One-cycle completion pulse |
| illegal | output | 1 | One-cycle illegal-instruction pulse |

## Verification
The assertions check these rules on every cycle:
- an illegal pulse comes with no memory or register activity;
- a request and its address are held until valid arrives;
- consecutive accepted reads step by one word;
- `done` is a single pulse that follows a register write;
- a request can only begin right after a start.

Only the bench scenarios can show the rest:
- that the right registers receive the right words in ascending order;
- that the write-back value equals base plus four per set bit, and is suppressed when the base is in the list;
- that a start strobe arriving mid-instruction leaves the outcome unchanged.

// File: rtl/mld_pkg.sv
package mld_pkg;

    localparam int INSTR_W = 16;
    localparam int OPC_W   = 5;
    localparam logic [OPC_W-1:0] OPC_LDM = 5'b11001;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOAD = 2'd1,
        ST_WB   = 2'd2
    } mld_state_e;

endpackage

// File: rtl/mld_decode.sv
module mld_decode
    import mld_pkg::*;
#(
    parameter int LIST_W = 8,
    localparam int IDX_W = $clog2(LIST_W)
) (
    input  logic [INSTR_W-1:0] instr,
    output logic               legal,
    output logic [IDX_W-1:0]   base,
    output logic [LIST_W-1:0]  list
);

    logic [OPC_W-1:0] opc;

    always_comb begin
        opc   = instr[INSTR_W-1 -: OPC_W];
        base  = instr[LIST_W +: IDX_W];
        list  = instr[LIST_W-1:0];
        // a load-multiple with nothing to load is refused
        legal = (opc == OPC_LDM) && (|list);
    end

endmodule

// File: rtl/mld_pick.sv
module mld_pick #(
    parameter int W = 8,
    localparam int IW = $clog2(W)
) (
    input  logic [W-1:0]  mask,
    output logic          found,
    output logic [IW-1:0] idx,
    output logic [W-1:0]  rest
);

    localparam logic [W-1:0] ONE = W'(1);

    logic [W-1:0] lowest;

    always_comb begin
        found  = |mask;
        lowest = mask & (~mask + ONE);
        rest   = mask & (mask - ONE);
    end

    // one-hot to binary: bit b of the index is the OR of positions with bit b set
    for (genvar b = 0; b < IW; b++) begin : g_enc
        logic [W-1:0] grp;
        for (genvar i = 0; i < W; i++) begin : g_pos
            assign grp[i] = ((i >> b) & 1) != 0;
        end
        assign idx[b] = |(lowest & grp);
    end

endmodule

// File: rtl/ldm_seq.sv
module ldm_seq
    import mld_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int LIST_W = 8,
    localparam int IDX_W = $clog2(LIST_W)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic [INSTR_W-1:0]   instr,
    output logic [IDX_W-1:0]     rf_raddr,
    input  logic [DATA_W-1:0]    rf_rdata,
    output logic                 rf_we,
    output logic [IDX_W-1:0]     rf_waddr,
    output logic [DATA_W-1:0]    rf_wdata,
    output logic                 mem_req,
    output logic [DATA_W-1:0]    mem_addr,
    input  logic                 mem_rvalid,
    input  logic [DATA_W-1:0]    mem_rdata,
    output logic                 done,
    output logic                 illegal
);

    localparam logic [DATA_W-1:0] STEP = DATA_W'(DATA_W / 8);

    typedef struct packed {
        mld_state_e        st;
        logic [LIST_W-1:0] mask;
        logic [DATA_W-1:0] addr;
        logic [IDX_W-1:0]  base;
        logic              wb_en;
        logic              done;
        logic              illegal;
    } seq_t;

    seq_t s_d, s_q;

    logic              dec_legal;
    logic [IDX_W-1:0]  dec_base;
    logic [LIST_W-1:0] dec_list;
    logic              pk_found;
    logic [IDX_W-1:0]  pk_idx;
    logic [LIST_W-1:0] pk_rest;

    mld_decode #(.LIST_W(LIST_W)) u_dec (
        .instr (instr),
        .legal (dec_legal),
        .base  (dec_base),
        .list  (dec_list)
    );

    mld_pick #(.W(LIST_W)) u_pick (
        .mask  (s_q.mask),
        .found (pk_found),
        .idx   (pk_idx),
        .rest  (pk_rest)
    );

    assign rf_raddr = dec_base;
    assign done     = s_q.done;
    assign illegal  = s_q.illegal;

    always_comb begin
        s_d         = s_q;
        s_d.done    = 1'b0;
        s_d.illegal = 1'b0;
        rf_we       = 1'b0;
        rf_waddr    = '0;
        rf_wdata    = '0;
        mem_req     = 1'b0;
        mem_addr    = s_q.addr;

        case (s_q.st)
            ST_IDLE: begin
                if (start) begin
                    if (dec_legal) begin
                        s_d.st    = ST_LOAD;
                        s_d.mask  = dec_list;
                        s_d.addr  = rf_rdata;
                        s_d.base  = dec_base;
                        s_d.wb_en = !dec_list[dec_base];
                    end else begin
                        s_d.illegal = 1'b1;
                    end
                end
            end
            ST_LOAD: begin
                mem_req = pk_found;
                if (pk_found && mem_rvalid) begin
                    rf_we    = 1'b1;
                    rf_waddr = pk_idx;
                    rf_wdata = mem_rdata;
                    s_d.mask = pk_rest;
                    s_d.addr = s_q.addr + STEP;
                    if (pk_rest == '0) begin
                        if (s_q.wb_en) begin
                            s_d.st = ST_WB;
                        end else begin
                            s_d.st   = ST_IDLE;
                            s_d.done = 1'b1;
                        end
                    end
                end else if (!pk_found) begin
                    s_d.st = ST_IDLE;
                end
            end
            ST_WB: begin
                rf_we    = 1'b1;
                rf_waddr = s_q.base;
                rf_wdata = s_q.addr;
                s_d.st   = ST_IDLE;
                s_d.done = 1'b1;
            end
            default: s_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{st: ST_IDLE, mask: '0, addr: '0, base: '0,
                     wb_en: 1'b0, done: 1'b0, illegal: 1'b0};
        end else begin
            s_q <= s_d;
        end
    end

endmodule

// File: rtl/mld_chk.sv
module mld_chk #(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              mem_req,
    input logic              mem_rvalid,
    input logic [DATA_W-1:0] mem_addr,
    input logic              rf_we,
    input logic              done,
    input logic              illegal
);

    localparam logic [DATA_W-1:0] STEP = DATA_W'(DATA_W / 8);

    // R2
    illegal_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> (!mem_req && !rf_we && !done));

    // R3
    addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_rvalid) |=> (mem_req && $stable(mem_addr)));

    // R3
    addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_rvalid) |=> (!mem_req || (mem_addr == $past(mem_addr) + STEP)));

    // R7
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R7
    done_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(rf_we));

    // R1
    req_after_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_req) |-> $past(start));

endmodule

bind ldm_seq mld_chk #(.DATA_W(DATA_W)) u_mld_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .mem_req    (mem_req),
    .mem_rvalid (mem_rvalid),
    .mem_addr   (mem_addr),
    .rf_we      (rf_we),
    .done       (done),
    .illegal    (illegal)
);

// File: tb/ldm_seq_bench.sv
module ldm_seq_bench;

    localparam int CLK_PERIOD = 10;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [15:0]   instr = '0;
    logic [2:0]    rf_raddr;
    logic [DW-1:0] rf_rdata;
    logic          rf_we;
    logic [2:0]    rf_waddr;
    logic [DW-1:0] rf_wdata;
    logic          mem_req;
    logic [DW-1:0] mem_addr;
    logic          mem_rvalid = 1'b0;
    logic [DW-1:0] mem_rdata = '0;
    logic          done;
    logic          illegal;

    always #(CLK_PERIOD/2) clk = ~clk;

    ldm_seq u_ldm_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .instr(instr),
        .rf_raddr(rf_raddr), .rf_rdata(rf_rdata),
        .rf_we(rf_we), .rf_waddr(rf_waddr), .rf_wdata(rf_wdata),
        .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
        .done(done), .illegal(illegal)
    );

    typedef struct {
        logic [2:0]    a;
        logic [DW-1:0] d;
        string         tag;
    } exp_t;

    exp_t sbq[$];

    int n_checks = 0;
    int n_fail   = 0;
    int cyc      = 0;
    int last_we  = -10;
    int done_cnt = 0;
    int ill_cnt  = 0;
    int req_cnt  = 0;
    int hs_cnt   = 0;
    int lat      = 0;
    int wait_cnt = 0;

    logic [DW-1:0] regs [8];
    assign rf_rdata = regs[rf_raddr];

    always @(posedge clk) if (rf_we) regs[rf_waddr] <= rf_wdata;

    function automatic logic [DW-1:0] mem_word(input logic [DW-1:0] a);
        return (a * 32'd7) ^ 32'hC3A5_1E0F;
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // memory responder with programmable latency
    always @(negedge clk) begin
        if (mem_req) begin
            if (wait_cnt >= lat) begin
                mem_rvalid <= 1'b1;
                mem_rdata  <= mem_word(mem_addr);
                wait_cnt   <= 0;
            end else begin
                mem_rvalid <= 1'b0;
                wait_cnt   <= wait_cnt + 1;
            end
        end else begin
            mem_rvalid <= 1'b0;
            wait_cnt   <= 0;
        end
    end

    // monitor: pops the scoreboard on each register write
    always begin
        @(negedge clk);
        #(CLK_PERIOD/4);
        cyc++;
        if (rst_n) begin
            if (mem_req) req_cnt++;
            if (mem_req && mem_rvalid) hs_cnt++;
            if (rf_we) begin
                if (sbq.size() == 0) begin
                    chk(1'b0, "R4", "unexpected write", {29'd0, rf_waddr}, '0);
                end else begin
                    exp_t e;
                    e = sbq.pop_front();
                    chk(rf_waddr == e.a, e.tag, "write index", {29'd0, rf_waddr}, {29'd0, e.a});
                    chk(rf_wdata == e.d, e.tag, "write data", rf_wdata, e.d);
                end
                last_we = cyc;
            end
            if (done) begin
                done_cnt++;
                chk(last_we == cyc - 1, "R7", "done one cycle after last write",
                    DW'(last_we), DW'(cyc - 1));
            end
            if (illegal) ill_cnt++;
        end
    end

    task automatic run(input logic [2:0] base, input logic [7:0] list,
                       input logic [4:0] opc, input logic [DW-1:0] bval,
                       input int lat_v, input bit intrude);
        logic [DW-1:0] a;
        bit legal;
        int d0, i0, r0, h0, n;
        @(negedge clk);
        lat = lat_v;
        regs[base] = bval;
        legal = (opc == 5'b11001) && (list != 0);
        a = bval;
        if (legal) begin
            for (int k = 0; k < 8; k++) begin
                if (list[k]) begin
                    exp_t e;
                    e.a = 3'(k);
                    e.d = mem_word(a);
                    e.tag = (3'(k) == base) ? "R6" : "R4";
                    sbq.push_back(e);
                    a = a + 32'd4;
                end
            end
            if (!list[base]) begin
                exp_t e;
                e.a = base;
                e.d = a;
                e.tag = "R5";
                sbq.push_back(e);
            end
        end
        d0 = done_cnt; i0 = ill_cnt; r0 = req_cnt; h0 = hs_cnt;
        instr = {opc, base, list};
        start = 1'b1;
        #(CLK_PERIOD/4);
        chk(rf_raddr == base, "R1", "base read index", {29'd0, rf_raddr}, {29'd0, base});
        @(negedge clk);
        start = 1'b0;
        if (intrude) begin
            @(negedge clk);
            @(negedge clk);
            instr = 16'hC9FF;
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        n = 0;
        while (done_cnt == d0 && ill_cnt == i0 && n < 200) begin
            @(posedge clk);
            n++;
        end
        repeat (4) @(posedge clk);
        if (legal) begin
            chk(done_cnt - d0 == 1, "R7", "done pulses", DW'(done_cnt - d0), 32'd1);
            chk(sbq.size() == 0, intrude ? "R8" : "R4", "writes left", DW'(sbq.size()), 32'd0);
            chk(hs_cnt - h0 == $countones(list), "R3", "accepted reads",
                DW'(hs_cnt - h0), DW'($countones(list)));
            chk(ill_cnt == i0, "R2", "no illegal on legal", DW'(ill_cnt - i0), 32'd0);
        end else begin
            chk(ill_cnt - i0 == 1, "R2", "illegal pulses", DW'(ill_cnt - i0), 32'd1);
            chk(req_cnt == r0, "R2", "no memory request", DW'(req_cnt - r0), 32'd0);
            chk(done_cnt == d0, "R2", "no done", DW'(done_cnt - d0), 32'd0);
            chk(sbq.size() == 0, "R2", "no write", DW'(sbq.size()), 32'd0);
        end
    endtask

    initial begin
        for (int k = 0; k < 8; k++) regs[k] = 32'h1111_1111 * k;
        repeat (2) @(negedge clk);
        #(CLK_PERIOD/4);
        // R9 reset state
        chk(!mem_req, "R9", "mem_req in reset", {31'd0, mem_req}, '0);
        chk(!rf_we, "R9", "rf_we in reset", {31'd0, rf_we}, '0);
        chk(!done, "R9", "done in reset", {31'd0, done}, '0);
        chk(!illegal, "R9", "illegal in reset", {31'd0, illegal}, '0);
        @(negedge clk);
        rst_n = 1'b1;

        run(3'd0, 8'h0E, 5'b11001, 32'h0000_0100, 0, 1'b0);  // R4 R5 zero wait
        run(3'd5, 8'hFF, 5'b11001, 32'h0000_2000, 2, 1'b0);  // R6 full list, slow memory
        run(3'd3, 8'h81, 5'b11001, 32'h0001_0040, 1, 1'b0);  // R3 sparse list
        run(3'd2, 8'h40, 5'b11001, 32'hFFFF_FFFC, 0, 1'b0);  // R5 single load, address wrap
        run(3'd7, 8'h80, 5'b11001, 32'h0000_0300, 3, 1'b0);  // R6 base is only entry
        run(3'd1, 8'hFF, 5'b11010, 32'h0000_0400, 0, 1'b0);  // R2 bad opcode
        run(3'd4, 8'h00, 5'b11001, 32'h0000_0500, 0, 1'b0);  // R2 empty list
        run(3'd6, 8'h3C, 5'b11001, 32'h0000_0800, 1, 1'b1);  // R8 start while busy

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule